// File: doc/BRIEF.md
# Configurable I/O Port with Peripheral Function Routing

This block controls a group of general-purpose pins. Each pin can run in one of two modes. In port mode, software drives the pin from an output latch and a direction bit. In alternate mode, one of four peripheral functions owns the pin, and two select bits per pin pick which one. The block sends the pad output value, the output enable and the open-drain flag to the pad. Pad levels are resynchronised and then routed back to software reads and to the peripheral inputs. A peripheral input is held low unless the pin is in alternate mode with that function selected.

Software reaches the configuration through a simple word-addressed register bus. A write strobe takes effect on the next clock edge, and the read data is combinational from the address. All register-bus, pad and peripheral pins are plain level signals with no handshake. A separate single-cycle command sets, clears or inverts one bit of the data register. The command works as a whole-register read-modify-write. Because of this, every pin in input mode has its current synchronised pad level copied into its latch.

Top module: `gpio_altmux_port`

## Requirements
- R1: After reset every direction bit is 1 (input), and every mode, latch, open-drain and select bit is 0. No pad is driven and every peripheral input is 0.
- R2: Reading address 0 (data) returns, for each pin, the latch bit when its direction bit is 0 and the synchronised pad level when its direction bit is 1.
- R3: A write to address 0 updates every latch bit on the next clock, whatever the direction and mode bits are. In port mode the pad output value always equals the latch.
- R4: A pad level reaches register reads and peripheral inputs after exactly two rising clock edges.
- R5: The peripheral input of function f at pin i is at bit f*N+i. It equals the synchronised pad level only when the pin's mode bit is 1 and its select value {sel_hi,sel_lo} equals f. Otherwise it is 0, so all of a pin's peripheral inputs are 0 in port mode.
- R6: In port mode the pad is driven when the direction bit is 0. Open-drain (address 3) is flagged to the pad only for a driving pin, and it turns the driver off while the driven value is 1. For an input pin it has no effect.
- R7: In alternate mode (address 2 bit = 1), the pad value and enable come from the selected function's output and enable lines (bit f*N+i). Open-drain is flagged with that enable and turns the driver off whenever the value is 1.
- R8: The bit command (op 1 = set, 2 = clear, 3 = invert, 0 = rewrite only) completes in one clock. It writes the current data-register read view back to every latch, with the target bit modified.
- R9: A bit command leaves the direction, mode, open-drain and select registers unchanged. A data write in the same cycle takes priority over the command.
- R10: Addresses are 0 data, 1 direction, 2 mode, 3 open-drain, 4 select low bit, 5 select high bit. Addresses 6 and 7 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | N | Register write data |
| reg_rdata | output | N | Combinational read data |
| bop_valid | input | 1 | Bit command strobe |
| bop_idx | input | log2(N) | Target bit of the command |
| bop_op | input | 2 | Command code |
| pad_i | input | N | Pad input levels (asynchronous) |
| pad_o | output | N | Pad output values |
| pad_oe | output | N | Pad driver enables |
| pad_od | output | N | Pad open-drain flags |
| alt_out | input | 4*N | Peripheral output values, function-major |
| alt_oe | input | 4*N | Peripheral output enables, function-major |
| alt_in | output | 4*N | Gated peripheral inputs, function-major |

## Verification
The hardest case to reach from the ports is a bit command on a port with mixed directions, where the pad disagrees with the latch on the input pins. The hidden latch bits change only there, and they become visible only after the pin is turned to output. The stimulus sets random direction and pad patterns, waits for the synchroniser to settle, and then issues commands. Afterwards it reads data back, and any later direction change exposes the copied latch bits. Directed cases add a data write colliding with a command and a pad edge sampled one and two clocks after it changes.

// File: rtl/gpio_altmux_pkg.sv
package gpio_altmux_pkg;
  localparam int SEL_W     = 2;
  localparam int NUM_FUNCS = 1 << SEL_W;

  typedef enum logic [2:0] {
    RA_DATA  = 3'd0,
    RA_DIR   = 3'd1,
    RA_MODE  = 3'd2,
    RA_ODEN  = 3'd3,
    RA_SELLO = 3'd4,
    RA_SELHI = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {
    BOP_REWRITE = 2'd0,
    BOP_SET     = 2'd1,
    BOP_CLR     = 2'd2,
    BOP_INV     = 2'd3
  } bop_e;
endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pad_i,
  output logic [N-1:0] pad_sync
);
  logic [N-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pad_i;
      sync_q <= meta_q;
    end
  end

  assign pad_sync = sync_q;

  // checker: count edges since reset so $past never reaches before it
  logic [1:0] seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else if (seen_q != 2'd2) seen_q <= seen_q + 2'd1;
  end

  assert_sync_two_edges_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q == 2'd2) |-> (pad_sync == $past(pad_i, 2)));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_altmux_pkg::*;
#(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [2:0]       addr,
  input  logic [N-1:0]     wdata,
  output logic [N-1:0]     rdata,
  input  logic             bop_valid,
  input  logic [IDX_W-1:0] bop_idx,
  input  logic [1:0]       bop_op,
  input  logic [N-1:0]     pad_sync,
  output logic [N-1:0]     latch,
  output logic [N-1:0]     dir,
  output logic [N-1:0]     mode,
  output logic [N-1:0]     oden,
  output logic [N-1:0]     sel_lo,
  output logic [N-1:0]     sel_hi
);
  logic [N-1:0] data_view, bop_next;
  logic         data_wr;

  assign data_view = (dir & pad_sync) | (~dir & latch);
  assign data_wr   = we && (addr == RA_DATA);

  always_comb begin
    case (addr)
      RA_DATA:  rdata = data_view;
      RA_DIR:   rdata = dir;
      RA_MODE:  rdata = mode;
      RA_ODEN:  rdata = oden;
      RA_SELLO: rdata = sel_lo;
      RA_SELHI: rdata = sel_hi;
      default:  rdata = '0;
    endcase
  end

  always_comb begin
    bop_next = data_view;
    case (bop_op)
      BOP_SET: bop_next[bop_idx] = 1'b1;
      BOP_CLR: bop_next[bop_idx] = 1'b0;
      BOP_INV: bop_next[bop_idx] = ~data_view[bop_idx];
      default: bop_next = data_view;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch  <= '0;
      dir    <= '1;
      mode   <= '0;
      oden   <= '0;
      sel_lo <= '0;
      sel_hi <= '0;
    end else begin
      if (data_wr)        latch <= wdata;
      else if (bop_valid) latch <= bop_next;
      if (we) begin
        case (addr)
          RA_DIR:   dir    <= wdata;
          RA_MODE:  mode   <= wdata;
          RA_ODEN:  oden   <= wdata;
          RA_SELLO: sel_lo <= wdata;
          RA_SELHI: sel_hi <= wdata;
          default:  ;
        endcase
      end
    end
  end

  assert_data_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> (latch == $past(wdata)));

  assert_bop_set_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bop_valid && !data_wr && bop_op == BOP_SET) |=> latch[$past(bop_idx)]);

  assert_bop_keeps_cfg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bop_valid && !we) |=> ($stable(dir) && $stable(mode) && $stable(oden)
                            && $stable(sel_lo) && $stable(sel_hi)));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_altmux_pkg::*;
#(
  parameter int N = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         latch,
  input  logic [N-1:0]         dir,
  input  logic [N-1:0]         mode,
  input  logic [N-1:0]         oden,
  input  logic [N-1:0]         sel_lo,
  input  logic [N-1:0]         sel_hi,
  input  logic [N-1:0]         pad_sync,
  input  logic [NUM_FUNCS*N-1:0] alt_out,
  input  logic [NUM_FUNCS*N-1:0] alt_oe,
  output logic [NUM_FUNCS*N-1:0] alt_in,
  output logic [N-1:0]         pad_o,
  output logic [N-1:0]         pad_oe,
  output logic [N-1:0]         pad_od
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    logic [SEL_W-1:0]     sel;
    logic [NUM_FUNCS-1:0] fo, fe, fin;
    logic                 drv_val, drv_en;

    assign sel = {sel_hi[i], sel_lo[i]};

    for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_fn
      assign fo[f]          = alt_out[f*N+i];
      assign fe[f]          = alt_oe[f*N+i];
      assign fin[f]         = mode[i] & (sel == SEL_W'(f)) & pad_sync[i];
      assign alt_in[f*N+i]  = fin[f];
    end

    assign drv_val   = mode[i] ? fo[sel] : latch[i];
    assign drv_en    = mode[i] ? fe[sel] : ~dir[i];
    assign pad_o[i]  = drv_val;
    assign pad_od[i] = oden[i] & drv_en;
    assign pad_oe[i] = drv_en & ~(oden[i] & drv_val);

    assert_port_altin_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !mode[i] |-> (fin == '0));

    assert_altin_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fin));

    assert_od_never_drives_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe[i] && pad_od[i]) |-> !pad_o[i]);

    assert_input_pin_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode[i] && dir[i]) |-> (!pad_oe[i] && !pad_od[i]));
  end
endmodule

// File: rtl/gpio_altmux_port.sv
module gpio_altmux_port
  import gpio_altmux_pkg::*;
#(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_we,
  input  logic [2:0]             reg_addr,
  input  logic [N-1:0]           reg_wdata,
  output logic [N-1:0]           reg_rdata,
  input  logic                   bop_valid,
  input  logic [IDX_W-1:0]       bop_idx,
  input  logic [1:0]             bop_op,
  input  logic [N-1:0]           pad_i,
  output logic [N-1:0]           pad_o,
  output logic [N-1:0]           pad_oe,
  output logic [N-1:0]           pad_od,
  input  logic [NUM_FUNCS*N-1:0] alt_out,
  input  logic [NUM_FUNCS*N-1:0] alt_oe,
  output logic [NUM_FUNCS*N-1:0] alt_in
);
  logic [N-1:0] pad_sync, latch, dir, mode, oden, sel_lo, sel_hi;

  gpio_pad_sync #(.N(N)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_i(pad_i), .pad_sync(pad_sync)
  );

  gpio_regs #(.N(N), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .bop_valid(bop_valid), .bop_idx(bop_idx), .bop_op(bop_op),
    .pad_sync(pad_sync), .latch(latch), .dir(dir), .mode(mode), .oden(oden),
    .sel_lo(sel_lo), .sel_hi(sel_hi)
  );

  gpio_pin_mux #(.N(N)) u_mux (
    .clk(clk), .rst_n(rst_n), .latch(latch), .dir(dir), .mode(mode), .oden(oden),
    .sel_lo(sel_lo), .sel_hi(sel_hi), .pad_sync(pad_sync), .alt_out(alt_out),
    .alt_oe(alt_oe), .alt_in(alt_in), .pad_o(pad_o), .pad_oe(pad_oe), .pad_od(pad_od)
  );
endmodule

// File: tb/gpio_altmux_port_bench.sv
`timescale 1ns/1ps
module gpio_altmux_port_bench;
  localparam int N = 8;
  localparam int F = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata;
  logic bop_valid = 1'b0;
  logic [2:0] bop_idx = '0;
  logic [1:0] bop_op = '0;
  logic [N-1:0] pad_i = '0;
  logic [N-1:0] pad_o, pad_oe, pad_od;
  logic [F*N-1:0] alt_out = '0;
  logic [F*N-1:0] alt_oe = '0;
  logic [F*N-1:0] alt_in;

  int total = 0;
  int bad = 0;

  logic [N-1:0] m_data = '0, m_dir = '1, m_mode = '0, m_od = '0, m_slo = '0, m_shi = '0;
  logic [N-1:0] m_pad = '0;

  always #10 clk = ~clk;

  gpio_altmux_port #(.N(N)) u_gpio_altmux_port (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bop_valid(bop_valid),
    .bop_idx(bop_idx), .bop_op(bop_op), .pad_i(pad_i), .pad_o(pad_o),
    .pad_oe(pad_oe), .pad_od(pad_od), .alt_out(alt_out), .alt_oe(alt_oe),
    .alt_in(alt_in)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] m_view();
    return (m_dir & m_pad) | (~m_dir & m_data);
  endfunction

  function automatic logic [N-1:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_view();
      3'd1: return m_dir;
      3'd2: return m_mode;
      3'd3: return m_od;
      3'd4: return m_slo;
      3'd5: return m_shi;
      default: return '0;
    endcase
  endfunction

  task automatic do_write(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    case (a)
      3'd0: m_data = d;
      3'd1: m_dir = d;
      3'd2: m_mode = d;
      3'd3: m_od = d;
      3'd4: m_slo = d;
      3'd5: m_shi = d;
      default: ;
    endcase
  endtask

  function automatic logic [N-1:0] m_bop(input logic [2:0] idx, input logic [1:0] op);
    logic [N-1:0] v = m_view();
    case (op)
      2'd1: v[idx] = 1'b1;
      2'd2: v[idx] = 1'b0;
      2'd3: v[idx] = ~v[idx];
      default: ;
    endcase
    return v;
  endfunction

  task automatic do_bop(input logic [2:0] idx, input logic [1:0] op);
    @(negedge clk);
    bop_valid = 1'b1; bop_idx = idx; bop_op = op;
    @(negedge clk);
    bop_valid = 1'b0;
    m_data = m_bop(idx, op);
  endtask

  task automatic set_pad(input logic [N-1:0] v);
    @(negedge clk);
    pad_i = v;
    @(negedge clk);
    @(negedge clk);
    m_pad = v;
  endtask

  task automatic check_read(input logic [2:0] a, input string tag);
    reg_addr = a;
    #1;
    chk(tag, 32'(reg_rdata), 32'(m_read(a)));
  endtask

  task automatic check_pins(input string tag);
    logic [N-1:0] eo, eoe, eod;
    logic [F*N-1:0] ein;
    #1;
    ein = '0;
    for (int i = 0; i < N; i++) begin
      int s = {m_shi[i], m_slo[i]};
      logic v = m_mode[i] ? alt_out[s*N+i] : m_data[i];
      logic e = m_mode[i] ? alt_oe[s*N+i] : ~m_dir[i];
      eo[i] = v;
      eod[i] = m_od[i] & e;
      eoe[i] = e & ~(m_od[i] & v);
      for (int f = 0; f < F; f++) ein[f*N+i] = m_mode[i] && (s == f) && m_pad[i];
    end
    chk({tag, " pad_o"}, 32'(pad_o), 32'(eo));
    chk({tag, " pad_oe"}, 32'(pad_oe), 32'(eoe));
    chk({tag, " pad_od"}, 32'(pad_od), 32'(eod));
    chk("R5 alt_in", alt_in, ein);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) check_read(3'(a), "R1 reset reg");
    check_pins("R1");

    // R4 two-edge synchroniser latency (all pins inputs)
    @(negedge clk);
    pad_i = 8'h3C; reg_addr = 3'd0;
    @(negedge clk); #1;
    chk("R4 one edge", 32'(reg_rdata), 32'h00);
    @(negedge clk); #1;
    chk("R4 two edges", 32'(reg_rdata), 32'h3C);
    m_pad = 8'h3C;

    // R3 latch written while input; port pad_o follows; R2 read shows pad
    do_write(3'd0, 8'h96);
    check_pins("R3");
    check_read(3'd0, "R2 input view");
    do_write(3'd1, 8'h0F);
    check_read(3'd0, "R2 mixed view");
    check_pins("R6");

    // R6 open-drain on port pins
    do_write(3'd3, 8'hFF);
    check_pins("R6 od");

    // R8 bit command copies pad into input latches: dir F0, pad A5
    set_pad(8'hA5);
    do_write(3'd0, 8'h00);
    do_write(3'd1, 8'hF0);
    do_bop(3'd0, 2'd1);
    do_write(3'd1, 8'h00);
    check_read(3'd0, "R8 set copy");
    chk("R8 literal", 32'(m_data), 32'hA1);
    do_write(3'd1, 8'hFF);
    do_bop(3'd7, 2'd3);
    do_write(3'd1, 8'h00);
    check_read(3'd0, "R8 invert");

    // R9 collision: data write wins, cfg unchanged
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h5A;
    bop_valid = 1'b1; bop_idx = 3'd1; bop_op = 2'd1;
    @(negedge clk);
    reg_we = 1'b0; bop_valid = 1'b0;
    m_data = 8'h5A;
    check_read(3'd0, "R9 write wins");
    do_bop(3'd2, 2'd2);
    for (int a = 1; a < 6; a++) check_read(3'(a), "R9 cfg kept");

    // R10 unmapped addresses
    do_write(3'd7, 8'hFF);
    do_write(3'd6, 8'hFF);
    for (int a = 0; a < 8; a++) check_read(3'(a), "R10 map");

    // R7 alternate mode with open-drain
    do_write(3'd2, 8'hFF);
    do_write(3'd4, 8'hAA);
    do_write(3'd5, 8'hCC);
    @(negedge clk);
    alt_out = 32'hF0F0_33CC; alt_oe = 32'hFFFF_FFFF;
    check_pins("R7 alt od");
    do_write(3'd3, 8'h00);
    check_pins("R7 alt");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int act = $urandom % 6;
      case (act)
        0, 1: do_write(3'($urandom % 8), 8'($urandom));
        2: do_bop(3'($urandom), 2'($urandom));
        3: set_pad(8'($urandom));
        4: begin
          @(negedge clk);
          alt_out = $urandom; alt_oe = $urandom;
        end
        default: do_write(3'($urandom % 3), 8'($urandom));
      endcase
      check_pins("R7");
      check_read(3'($urandom % 8), "R2");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule